// File: doc/BRIEF.md
# Serial Slave Front End for a Byte-Wide SRAM

This block lets an SPI master read and write a byte-wide on-chip SRAM at full bus speed. The master lowers chip select and sends a command byte. For memory commands it then sends a 24-bit address, most significant byte first, and after that the data. Data moves in either direction with no dummy cycles and no gaps between bytes. The address steps up by one after every byte and wraps from the top of the array to zero, so one command can cover any length of data.

The block also holds a write-enable latch and a two-bit protection field in a small status byte. It takes a hardware write-protect pin, a hold pin that pauses the serial stream, and a busy input from a store/recall sequencer. While busy is high, memory commands are refused. The block sends the sequencer a one-cycle strobe for every byte that actually reaches the array.

All serial pins are sampled in the `clk` domain, and SCK edges are found by comparing each sample with the previous one. SCK must therefore stay at each level for at least two `clk` periods. The array depth is `2**ADDR_W` bytes. The full-size build uses `ADDR_W` = 17, and the default is smaller so that the model elaborates quickly.

Top module: `spi_sram_slave`

## Requirements
- R1: SI is captured on rising SCK edges and SO changes only on falling SCK edges. This holds whether SCK idles low (mode 0) or high (mode 3) while chip select is high.
- R2: Opcode 0x02 followed by three address bytes starts a write. Each later byte is written to the current address, using only the low ADDR_W address bits, and the first data byte goes in with no extra cycles.
- R3: Opcode 0x03 followed by three address bytes starts a read. The byte at that address appears on SO from the very next SCK edge, with so_oe high throughout the data phase.
- R4: During a burst the address goes up by one after each byte. After address 2**ADDR_W-1 it continues at 0.
- R5: While hold_n is low, SCK edges are ignored and so_oe is low. After hold_n goes high, the transfer continues from the bit where it stopped.
- R6: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is also cleared when chip select rises after a write (0x02) or status write (0x01) command. No array byte or status write takes effect while the latch is clear.
- R7: While wp_n is low, no array byte and no status write takes effect.
- R8: Status field BP (status bits 3:2) protects address ranges from writes. 00 protects nothing, 01 protects the top quarter (two top address bits both 1), 10 protects the top half (top address bit 1), and 11 protects the whole array.
- R9: A read or write opcode received while busy is high is dropped: so_oe stays low and nothing is written. A data byte that completes while busy is high is not written.
- R10: Opcode 0x05 returns the status byte {4'b0, BP[1:0], WEL, busy} on SO. Opcode 0x01 followed by a byte loads BP from that byte's bits 3:2.
- R11: While cs_n is high, so_oe is low and the command decoder is back at the opcode byte.
- R12: wr_pulse is high for exactly one clk cycle for each byte written into the array, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pauses serial activity while low |
| wp_n | input | 1 | Hardware write protect, active low |
| busy | input | 1 | Store or recall in progress |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad driver |
| wr_pulse | output | 1 | One-cycle strobe per byte written |

## Verification
The hardest case is a hold that lands in the middle of a data byte. The gated SCK has to toggle while hold is low and be back at its old level before hold is released, so the bench inserts the hold inside a bit period of the first data byte of both a write and a read. It then checks both the stored value and the byte that comes back after the pause. The wrap and protection-boundary cases need bursts that start just below the array top and the quarter and half boundaries. Random transactions in both SPI modes, with random upper address bits, then mix with these directed cases.

// File: rtl/spi_sram_pkg.sv
`timescale 1ns/1ps
package spi_sram_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_READ = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_STATUS,
    PH_SETSTAT,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_bit_engine.sv
`timescale 1ns/1ps
module spi_bit_engine
  import spi_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              sck,
  input  logic              si,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              fall_ev,
  output logic              byte_start,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              so_bit
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_q;
  logic              active;
  logic              rise_ev;
  logic [CNT_W-1:0]  bit_cnt, bit_cnt_n;
  logic [BYTE_W-2:0] rx_sh, rx_sh_n;
  logic [BYTE_W-1:0] tx_sh, tx_sh_n;

  assign active     = ~cs_n & hold_n;
  assign rise_ev    = active & sck & ~sck_q;
  assign fall_ev    = active & ~sck & sck_q;
  assign byte_start = (bit_cnt == '0);
  assign byte_done  = rise_ev & (bit_cnt == CNT_W'(BYTE_W - 1));
  assign rx_byte    = {rx_sh, si};
  assign so_bit     = tx_sh[BYTE_W-1];

  always_comb begin
    bit_cnt_n = bit_cnt;
    rx_sh_n   = rx_sh;
    tx_sh_n   = tx_sh;
    if (cs_n) begin
      bit_cnt_n = '0;
    end else if (rise_ev) begin
      bit_cnt_n = bit_cnt + CNT_W'(1);
      rx_sh_n   = {rx_sh[BYTE_W-3:0], si};
    end
    if (fall_ev) begin
      tx_sh_n = tx_load ? tx_data : {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      sck_q   <= sck;
      bit_cnt <= bit_cnt_n;
      rx_sh   <= rx_sh_n;
      tx_sh   <= tx_sh_n;
    end
  end
endmodule

// File: rtl/spi_cmd_ctrl.sv
`timescale 1ns/1ps
module spi_cmd_ctrl
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              fall_ev,
  input  logic              byte_start,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              reading,
  output logic              wr_pulse
);
  localparam int ADDR_BYTES = 3;
  localparam int AC_W = $clog2(ADDR_BYTES);

  phase_t            phase, phase_n;
  logic [AC_W-1:0]   ad_cnt, ad_cnt_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              wel, wel_n;
  logic [1:0]        bp, bp_n;
  logic              rd_cmd, rd_cmd_n;
  logic              wr_txn, wr_txn_n;
  logic              prot;
  logic [BYTE_W-1:0] status;

  always_comb begin
    case (bp)
      2'b01:   prot = &addr[ADDR_W-1 -: 2];
      2'b10:   prot = addr[ADDR_W-1];
      2'b11:   prot = 1'b1;
      default: prot = 1'b0;
    endcase
  end

  assign status   = {4'b0000, bp, wel, busy};
  assign mem_addr = addr;
  assign reading  = (phase == PH_RDATA) || (phase == PH_STATUS);

  always_comb begin
    phase_n  = phase;
    ad_cnt_n = ad_cnt;
    addr_n   = addr;
    wel_n    = wel;
    bp_n     = bp;
    rd_cmd_n = rd_cmd;
    wr_txn_n = wr_txn;
    mem_we   = 1'b0;
    tx_load  = 1'b0;
    tx_data  = (phase == PH_STATUS) ? status : mem_rdata;
    if (cs_n) begin
      phase_n  = PH_OPCODE;
      ad_cnt_n = '0;
      if (wr_txn) begin
        wel_n    = 1'b0;
        wr_txn_n = 1'b0;
      end
    end else begin
      if (byte_done) begin
        case (phase)
          PH_OPCODE: begin
            case (rx_byte)
              OP_READ: begin
                phase_n  = busy ? PH_SKIP : PH_ADDR;
                rd_cmd_n = 1'b1;
              end
              OP_WRITE: begin
                phase_n  = busy ? PH_SKIP : PH_ADDR;
                rd_cmd_n = 1'b0;
                wr_txn_n = 1'b1;
              end
              OP_WREN: begin
                wel_n   = 1'b1;
                phase_n = PH_SKIP;
              end
              OP_WRDI: begin
                wel_n   = 1'b0;
                phase_n = PH_SKIP;
              end
              OP_RDSR: phase_n = PH_STATUS;
              OP_WRSR: begin
                phase_n  = PH_SETSTAT;
                wr_txn_n = 1'b1;
              end
              default: phase_n = PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            addr_n   = {addr[ADDR_W-BYTE_W-1:0], rx_byte};
            ad_cnt_n = ad_cnt + AC_W'(1);
            if (ad_cnt == AC_W'(ADDR_BYTES - 1)) begin
              phase_n = rd_cmd ? PH_RDATA : PH_WDATA;
            end
          end
          PH_WDATA: begin
            mem_we = wel & wp_n & ~busy & ~prot;
            addr_n = addr + ADDR_W'(1);
          end
          PH_SETSTAT: begin
            if (wel && wp_n) begin
              bp_n = rx_byte[3:2];
            end
            phase_n = PH_SKIP;
          end
          default: ;
        endcase
      end
      if (fall_ev && byte_start && reading) begin
        tx_load = 1'b1;
        if (phase == PH_RDATA) begin
          addr_n = addr + ADDR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPCODE;
      ad_cnt   <= '0;
      addr     <= '0;
      wel      <= 1'b0;
      bp       <= 2'b00;
      rd_cmd   <= 1'b0;
      wr_txn   <= 1'b0;
      wr_pulse <= 1'b0;
    end else begin
      phase    <= phase_n;
      ad_cnt   <= ad_cnt_n;
      addr     <= addr_n;
      wel      <= wel_n;
      bp       <= bp_n;
      rd_cmd   <= rd_cmd_n;
      wr_txn   <= wr_txn_n;
      wr_pulse <= mem_we;
    end
  end
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/spi_sram_slave.sv
`timescale 1ns/1ps
module spi_sram_slave
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  input  logic busy,
  output logic so,
  output logic so_oe,
  output logic wr_pulse
);
  logic              fall_ev;
  logic              byte_start;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_data;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [BYTE_W-1:0] mem_rdata;
  logic              reading;

  spi_bit_engine u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .hold_n     (hold_n),
    .sck        (sck),
    .si         (si),
    .tx_load    (tx_load),
    .tx_data    (tx_data),
    .fall_ev    (fall_ev),
    .byte_start (byte_start),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .so_bit     (so)
  );

  spi_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .wp_n       (wp_n),
    .busy       (busy),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .fall_ev    (fall_ev),
    .byte_start (byte_start),
    .mem_rdata  (mem_rdata),
    .tx_load    (tx_load),
    .tx_data    (tx_data),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .reading    (reading),
    .wr_pulse   (wr_pulse)
  );

  sram_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (rx_byte),
    .rdata (mem_rdata)
  );

  assign so_oe = ~cs_n & hold_n & reading;
endmodule

// File: rtl/spi_sram_slave_chk.sv
`timescale 1ns/1ps
module spi_sram_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic wp_n,
  input logic busy,
  input logic so_oe,
  input logic wr_pulse
);
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_oe); // R11

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |-> !so_oe); // R5

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && $past(!hold_n)) |-> !wr_pulse); // R5

  AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && $past(!wp_n)) |-> !wr_pulse); // R7

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !wr_pulse); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R12
endmodule

bind spi_sram_slave spi_sram_slave_chk u_chk (.*);

// File: tb/tb_spi_sram_slave.sv
`timescale 1ns/1ps
module tb_spi_sram_slave;
  localparam int AW = 12;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = 2;

  logic clk, rst_n, cs_n, sck, si, hold_n, wp_n, busy;
  logic so, so_oe, wr_pulse;

  spi_sram_slave #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .busy(busy),
    .so(so), .so_oe(so_oe), .wr_pulse(wr_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int pulse_cnt = 0;
  int exp_pulses = 0;
  logic [7:0] sh_mem [DEPTH];
  bit sh_val [DEPTH];
  bit m_wel = 0;
  logic [1:0] m_bp = 2'b00;
  logic last_oe;
  bit hold_req = 0;
  logic [7:0] wbuf [8];

  always @(negedge clk) if (rst_n && wr_pulse) pulse_cnt++;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish act=timeout exp=done");
    report();
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit prot(input logic [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'b01: return a[AW-1] && a[AW-2];
      2'b10: return a[AW-1];
      2'b11: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {4'b0000, m_bp, m_wel, busy};
  endfunction

  task automatic cw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si = tx[i];
      cw(HALF);
      if (hold_req && i == 4) begin
        hold_n = 1'b0;
        cw(2);
        check("R5 so_oe low in hold", so_oe, 0);
        sck = 1'b1; cw(3);
        sck = 1'b0; cw(3);
        hold_n = 1'b1;
        cw(2);
        hold_req = 0;
      end
      rx[i] = so;
      last_oe = so_oe;
      sck = 1'b1;
      cw(HALF);
    end
  endtask

  task automatic begin_txn(input bit m3);
    sck = m3;
    cw(2);
    cs_n = 1'b0;
    cw(2);
  endtask

  task automatic end_txn(input bit m3);
    sck = m3;
    cw(2);
    cs_n = 1'b1;
    cw(3);
  endtask

  task automatic cmd1(input bit m3, input logic [7:0] op);
    logic [7:0] d;
    begin_txn(m3);
    xfer(op, d);
    end_txn(m3);
    if (op == 8'h06) m_wel = 1;
    if (op == 8'h04) m_wel = 0;
  endtask

  task automatic rdsr(input bit m3, output logic [7:0] st);
    logic [7:0] d;
    begin_txn(m3);
    xfer(8'h05, d);
    xfer(8'h00, st);
    end_txn(m3);
  endtask

  task automatic wrsr(input bit m3, input logic [7:0] v);
    logic [7:0] d;
    begin_txn(m3);
    xfer(8'h01, d);
    xfer(v, d);
    end_txn(m3);
    if (m_wel && wp_n) m_bp = v[3:2];
    m_wel = 0;
  endtask

  task automatic send_addr(input logic [23:0] a24);
    logic [7:0] d;
    xfer(a24[23:16], d);
    xfer(a24[15:8], d);
    xfer(a24[7:0], d);
  endtask

  task automatic write_txn(input bit m3, input logic [23:0] a24, input int n, input bit hold);
    logic [7:0] d;
    logic [AW-1:0] ai;
    bit was_busy;
    was_busy = busy;
    begin_txn(m3);
    xfer(8'h02, d);
    send_addr(a24);
    for (int i = 0; i < n; i++) begin
      if (i == 0) hold_req = hold;
      xfer(wbuf[i], d);
    end
    end_txn(m3);
    if (!was_busy) begin
      for (int i = 0; i < n; i++) begin
        ai = a24[AW-1:0] + AW'(i);
        if (m_wel && wp_n && !prot(m_bp, ai)) begin
          sh_mem[ai] = wbuf[i];
          sh_val[ai] = 1;
          exp_pulses++;
        end
      end
    end
    m_wel = 0;
    check("R12 write strobe count", pulse_cnt, exp_pulses);
  endtask

  task automatic read_txn(input bit m3, input logic [23:0] a24, input int n, input bit hold);
    logic [7:0] d, rx;
    logic [AW-1:0] ai;
    bit was_busy;
    was_busy = busy;
    begin_txn(m3);
    xfer(8'h03, d);
    send_addr(a24);
    for (int i = 0; i < n; i++) begin
      if (i == 0) hold_req = hold;
      xfer(8'h00, rx);
      ai = a24[AW-1:0] + AW'(i);
      if (was_busy) begin
        check("R9 so_oe low on read while busy", last_oe, 0);
      end else begin
        check("R3 so_oe high in read data", last_oe, 1);
        if (sh_val[ai]) check(m3 ? "R1 R3 R4 read data mode3" : "R1 R3 R4 read data mode0", rx, sh_mem[ai]);
      end
    end
    end_txn(m3);
    check("R11 so_oe low after deselect", so_oe, 0);
  endtask

  initial begin
    logic [7:0] st, d;
    logic [23:0] a24;
    bit m3;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < DEPTH; i++) sh_val[i] = 0;
    rst_n = 0; cs_n = 1; sck = 0; si = 0; hold_n = 1; wp_n = 1; busy = 0;
    cw(5);
    rst_n = 1;
    cw(2);
    check("R11 so_oe low after reset", so_oe, 0);
    check("R12 no strobe after reset", wr_pulse, 0);
    rdsr(0, st);
    check("R10 status after reset", st, 8'h00);

    cmd1(0, 8'h06);
    rdsr(1, st);
    check("R6 R10 WEL set by 0x06", st, 8'h02);
    cmd1(1, 8'h04);
    rdsr(0, st);
    check("R6 WEL cleared by 0x04", st, 8'h00);

    // R6: write without latch is dropped
    wbuf[0] = 8'h3C;
    cmd1(0, 8'h06);
    write_txn(0, 24'h000010, 1, 0);
    wbuf[0] = 8'hA5;
    write_txn(0, 24'h000010, 1, 0);
    read_txn(1, 24'h000010, 1, 0);
    rdsr(0, st);
    check("R6 WEL cleared after write", st, 8'h00);

    // R2 R4: burst across the top of the array, upper address bits ignored
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    cmd1(1, 8'h06);
    write_txn(1, 24'hAB0FFE, 4, 0);
    read_txn(0, 24'h000FFE, 4, 0);
    read_txn(1, 24'h000000, 2, 0);

    // R7: hardware protect blocks array and status writes
    wbuf[0] = 8'h5A;
    cmd1(0, 8'h06);
    write_txn(0, 24'h000020, 1, 0);
    wp_n = 0;
    wbuf[0] = 8'hFF;
    cmd1(0, 8'h06);
    write_txn(0, 24'h000020, 1, 0);
    cmd1(0, 8'h06);
    wrsr(0, 8'h0C);
    wp_n = 1;
    read_txn(0, 24'h000020, 1, 0);
    rdsr(0, st);
    check("R7 status write blocked by wp_n", st, 8'h00);

    // R8: each protection setting, bursts across the quarter and half bounds
    for (int b = 1; b < 4; b++) begin
      cmd1(b[0], 8'h06);
      wrsr(b[0], {4'b0, b[1:0], 2'b00});
      rdsr(0, st);
      check("R8 R10 BP readback", st, {4'b0, b[1:0], 2'b00});
      for (int k = 0; k < 4; k++) wbuf[k] = 8'(b * 16 + k);
      cmd1(0, 8'h06);
      write_txn(0, 24'h000BFE, 4, 0);
      cmd1(1, 8'h06);
      write_txn(1, 24'h0007FE, 4, 0);
      read_txn(0, 24'h000BFE, 4, 0);
      read_txn(1, 24'h0007FE, 4, 0);
    end
    cmd1(0, 8'h06);
    wrsr(0, 8'h00);

    // R9: busy refuses memory commands
    busy = 1;
    rdsr(0, st);
    check("R9 R10 busy bit in status", st, 8'h01);
    read_txn(0, 24'h000010, 2, 0);
    wbuf[0] = 8'h99;
    cmd1(0, 8'h06);
    write_txn(0, 24'h000010, 1, 0);
    busy = 0;
    read_txn(1, 24'h000010, 1, 0);

    // R5: hold in the middle of a data byte
    wbuf[0] = 8'hC3; wbuf[1] = 8'h7E;
    cmd1(0, 8'h06);
    write_txn(0, 24'h000100, 2, 1);
    read_txn(1, 24'h000100, 2, 1);
    read_txn(0, 24'h000100, 2, 0);

    // R11: deselect in the middle of an address restarts decoding
    begin_txn(0);
    xfer(8'h03, d);
    xfer(8'h00, d);
    end_txn(0);
    check("R11 so_oe low after abort", so_oe, 0);
    rdsr(1, st);
    check("R11 decoder restarted at opcode", st, exp_status());

    // random mix
    for (int t = 0; t < 40; t++) begin
      m3 = 1'($urandom % 2);
      a24 = 24'($urandom);
      if ($urandom % 4 == 0) a24[AW-1:0] = AW'(DEPTH - 2);
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      case ($urandom % 3)
        0: begin
          cmd1(m3, 8'h06);
          write_txn(m3, a24, 1 + int'($urandom % 4), 0);
        end
        1: write_txn(m3, a24, 1 + int'($urandom % 4), 0);
        default: read_txn(m3, a24, 1 + int'($urandom % 4), 0);
      endcase
    end
    for (int t = 0; t < 8; t++) read_txn(t % 2 == 1, 24'(t * 333), 4, 0);
    check("R12 final strobe count", pulse_cnt, exp_pulses);

    report();
    $finish;
  end
endmodule